// File: doc/BRIEF.md
# UART FIFO-Level Interrupt Controller

This block decides when a UART with transmit and receive FIFOs should raise its interrupt. It watches the occupancy count, full flag and empty flag of each FIFO and compares them with thresholds that software sets. It also takes a pulse from a receive idle timer. From these it builds a transmit-ready condition, a receive-ready condition and a sticky idle-gap flag. It drives one level interrupt request and a small word-addressed register window for status, control, thresholds and occupancy.

The FIFOs may report a narrow occupancy count of log2(depth) bits. That count reads zero both when the FIFO is empty and when it is completely full. Every decision in this block therefore uses the full flag together with the count. Because of this, a FIFO that fills to its exact depth cannot drop a pending interrupt and cannot raise a false one. The transmit and receive depths are separate parameters. A parameter can instead select a count one bit wider, which FIFOs of that kind report directly.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: A read at word offset 6 returns the RX occupancy and a read at offset 7 returns the TX occupancy, both zero-extended to 32 bits. When the narrow count is used and the FIFO is full, the value read is the FIFO depth. The TX and RX depths are independent (16 and 32 by default).
- R2: TX-ready (status bit 0) is 1 exactly when the TX occupancy is at or below the TX threshold and the TX FIFO is not full.
- R3: The RX-threshold flag (status bit 13) is 1 when the RX occupancy is at or above the RX threshold, or when the RX FIFO is full. RX-ready (status bit 1) is that flag ORed with the idle-gap flag.
- R4: The idle-gap flag (status bit 14) is set one cycle after a timeout pulse that arrives while the RX FIFO is not empty. A pulse that arrives while the RX FIFO is empty has no effect. The flag is cleared in the cycle after the RX FIFO is empty, or after a write to offset 2 with bit 14 set. A pulse in the same cycle as that write wins over the clear.
- R5: The control register sits at offset 3. Bit 0 enables the TX-ready source and bit 1 enables the RX-ready source. irq_o is registered: it equals the OR of the enabled sources as they stood at the previous clock edge.
- R6: The TX threshold is at offset 4 and the RX threshold at offset 5. Both can be written and read back. A written value larger than the FIFO depth is stored as the depth.
- R7: When a FIFO fills to its exact depth and its narrow count wraps to 0, TX-ready goes low and RX-ready goes high. irq_o follows those values and takes none from the wrapped count.
- R8: After reset, irq_o is 0, the control register is 0, the TX threshold is 0, the RX threshold is 1 and the idle-gap flag is 0. Offsets 0 and 1 read as 0, and writes to read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_used_i | input | TX_CW | TX FIFO occupancy count |
| tx_full_i | input | 1 | TX FIFO full |
| tx_empty_i | input | 1 | TX FIFO empty |
| rx_used_i | input | RX_CW | RX FIFO occupancy count |
| rx_full_i | input | 1 | RX FIFO full |
| rx_empty_i | input | 1 | RX FIFO empty |
| rx_gap_tmo_i | input | 1 | Receive idle-gap timeout pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from offset) |
| irq_o | output | 1 | Level interrupt request |

## Verification
A ready condition that ignores the full flag shows up at the exact moment a FIFO reaches its depth. At that point the status word and the occupancy read disagree with the model in the same cycle, and irq_o disagrees one clock later. A stale or badly gated idle-gap flag shows in status bit 14 one cycle after the pulse, the clear or the emptying of the FIFO. A clamp or enable fault shows on the next read-back of the register. Because the reference model is compared against the ports on every clock, each of these faults is caught within one or two cycles of the stimulus that exposes it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned ADDR_W = 3;
  // word offsets; 6 and 7 are fixed by the driver
  localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_TX_THR = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_RX_THR = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_RX_OCC = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_TX_OCC = 3'd7;
  // status bits; 13/14 ordering is shared with software
  localparam int unsigned ST_TX_RDY   = 0;
  localparam int unsigned ST_RX_RDY   = 1;
  localparam int unsigned ST_TX_FULL  = 2;
  localparam int unsigned ST_RX_FULL  = 3;
  localparam int unsigned ST_TX_EMPTY = 4;
  localparam int unsigned ST_RX_EMPTY = 5;
  localparam int unsigned ST_RX_THR   = 13;
  localparam int unsigned ST_GAP      = 14;
  localparam int unsigned CTRL_TX_EN  = 0;
  localparam int unsigned CTRL_RX_EN  = 1;
endpackage

// File: rtl/fifo_level_decode.sv
module fifo_level_decode #(
  parameter int unsigned DEPTH = 16,
  parameter bit          WIDE  = 1'b0,
  parameter int unsigned CW    = $clog2(DEPTH) + (WIDE ? 1 : 0),
  parameter int unsigned LW    = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] used_i,
  input  logic          full_i,
  output logic [LW-1:0] level_o
);
  generate
    if (WIDE) begin : g_wide
      logic unused_full;
      assign unused_full = full_i;
      assign level_o = LW'(used_i);
    end else begin : g_narrow
      // narrow count wraps to 0 at full depth
      assign level_o = full_i ? LW'(DEPTH) : LW'(used_i);
    end
  endgenerate
endmodule

// File: rtl/uart_irq_cfg_regs.sv
module uart_irq_cfg_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 32,
  parameter int unsigned TLW = $clog2(TX_DEPTH) + 1,
  parameter int unsigned RLW = $clog2(RX_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic [TLW-1:0]    tx_thr_o,
  output logic [RLW-1:0]    rx_thr_o,
  output logic              gap_wclr_o
);
  logic [TLW-1:0] tx_thr_d;
  logic [RLW-1:0] rx_thr_d;

  always_comb begin
    tx_thr_d = (wdata_i > 32'(TX_DEPTH)) ? TLW'(TX_DEPTH) : wdata_i[TLW-1:0];
    rx_thr_d = (wdata_i > 32'(RX_DEPTH)) ? RLW'(RX_DEPTH) : wdata_i[RLW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_o  <= 1'b0;
      rx_en_o  <= 1'b0;
      tx_thr_o <= '0;
      rx_thr_o <= RLW'(1);
    end else if (we_i) begin
      case (addr_i)
        OFS_CTRL: begin
          tx_en_o <= wdata_i[CTRL_TX_EN];
          rx_en_o <= wdata_i[CTRL_RX_EN];
        end
        OFS_TX_THR: tx_thr_o <= tx_thr_d;
        OFS_RX_THR: rx_thr_o <= rx_thr_d;
        default: ;
      endcase
    end
  end

  assign gap_wclr_o = we_i && (addr_i == OFS_STATUS) && wdata_i[ST_GAP];
endmodule

// File: rtl/uart_irq_core.sv
module uart_irq_core #(
  parameter int unsigned TLW = 5,
  parameter int unsigned RLW = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [TLW-1:0] tx_level_i,
  input  logic           tx_full_i,
  input  logic [RLW-1:0] rx_level_i,
  input  logic           rx_full_i,
  input  logic           rx_empty_i,
  input  logic           gap_tmo_i,
  input  logic           gap_wclr_i,
  input  logic [TLW-1:0] tx_thr_i,
  input  logic [RLW-1:0] rx_thr_i,
  input  logic           tx_en_i,
  input  logic           rx_en_i,
  output logic           tx_ready_o,
  output logic           rx_hit_o,
  output logic           rx_ready_o,
  output logic           gap_o,
  output logic           irq_o
);
  logic gap_q, irq_q;

  assign tx_ready_o = (tx_level_i <= tx_thr_i) && !tx_full_i;
  assign rx_hit_o   = (rx_level_i >= rx_thr_i) || rx_full_i;
  assign rx_ready_o = rx_hit_o || gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      // a fresh timeout beats a software clear
      gap_q <= !rx_empty_i && (gap_tmo_i || (gap_q && !gap_wclr_i));
      irq_q <= (tx_en_i && tx_ready_o) || (rx_en_i && rx_ready_o);
    end
  end

  assign gap_o = gap_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
module uart_fifo_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned TX_DEPTH   = 16,
  parameter int unsigned RX_DEPTH   = 32,
  parameter bit          WIDE_COUNT = 1'b0,
  parameter int unsigned TX_CW = $clog2(TX_DEPTH) + (WIDE_COUNT ? 1 : 0),
  parameter int unsigned RX_CW = $clog2(RX_DEPTH) + (WIDE_COUNT ? 1 : 0)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TX_CW-1:0]  tx_used_i,
  input  logic              tx_full_i,
  input  logic              tx_empty_i,
  input  logic [RX_CW-1:0]  rx_used_i,
  input  logic              rx_full_i,
  input  logic              rx_empty_i,
  input  logic              rx_gap_tmo_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned TLW = $clog2(TX_DEPTH) + 1;
  localparam int unsigned RLW = $clog2(RX_DEPTH) + 1;

  logic [TLW-1:0] tx_level_w, tx_thr_w;
  logic [RLW-1:0] rx_level_w, rx_thr_w;
  logic tx_en_w, rx_en_w, gap_wclr_w;
  logic tx_ready_w, rx_hit_w, rx_ready_w, gap_w;

  fifo_level_decode #(.DEPTH(TX_DEPTH), .WIDE(WIDE_COUNT), .CW(TX_CW), .LW(TLW)) u_tx_lvl (
    .used_i(tx_used_i), .full_i(tx_full_i), .level_o(tx_level_w)
  );

  fifo_level_decode #(.DEPTH(RX_DEPTH), .WIDE(WIDE_COUNT), .CW(RX_CW), .LW(RLW)) u_rx_lvl (
    .used_i(rx_used_i), .full_i(rx_full_i), .level_o(rx_level_w)
  );

  uart_irq_cfg_regs #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .TLW(TLW), .RLW(RLW)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .tx_en_o(tx_en_w), .rx_en_o(rx_en_w),
    .tx_thr_o(tx_thr_w), .rx_thr_o(rx_thr_w), .gap_wclr_o(gap_wclr_w)
  );

  uart_irq_core #(.TLW(TLW), .RLW(RLW)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tx_level_i(tx_level_w), .tx_full_i(tx_full_i),
    .rx_level_i(rx_level_w), .rx_full_i(rx_full_i), .rx_empty_i(rx_empty_i),
    .gap_tmo_i(rx_gap_tmo_i), .gap_wclr_i(gap_wclr_w),
    .tx_thr_i(tx_thr_w), .rx_thr_i(rx_thr_w),
    .tx_en_i(tx_en_w), .rx_en_i(rx_en_w),
    .tx_ready_o(tx_ready_w), .rx_hit_o(rx_hit_w), .rx_ready_o(rx_ready_w),
    .gap_o(gap_w), .irq_o(irq_o)
  );

  logic [31:0] status_w;
  always_comb begin
    status_w              = '0;
    status_w[ST_TX_RDY]   = tx_ready_w;
    status_w[ST_RX_RDY]   = rx_ready_w;
    status_w[ST_TX_FULL]  = tx_full_i;
    status_w[ST_RX_FULL]  = rx_full_i;
    status_w[ST_TX_EMPTY] = tx_empty_i;
    status_w[ST_RX_EMPTY] = rx_empty_i;
    status_w[ST_RX_THR]   = rx_hit_w;
    status_w[ST_GAP]      = gap_w;
  end

  always_comb begin
    case (reg_addr_i)
      OFS_STATUS: reg_rdata_o = status_w;
      OFS_CTRL:   reg_rdata_o = {30'd0, rx_en_w, tx_en_w};
      OFS_TX_THR: reg_rdata_o = 32'(tx_thr_w);
      OFS_RX_THR: reg_rdata_o = 32'(rx_thr_w);
      OFS_RX_OCC: reg_rdata_o = 32'(rx_level_w);
      OFS_TX_OCC: reg_rdata_o = 32'(tx_level_w);
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_fifo_irq_ctrl_chk.sv
module uart_fifo_irq_ctrl_chk #(
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 32,
  parameter int unsigned TLW = $clog2(TX_DEPTH) + 1,
  parameter int unsigned RLW = $clog2(RX_DEPTH) + 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           tx_full_i,
  input logic           rx_full_i,
  input logic           rx_empty_i,
  input logic           tx_ready,
  input logic           rx_ready,
  input logic           gap,
  input logic           tx_en,
  input logic           rx_en,
  input logic [TLW-1:0] tx_thr,
  input logic [RLW-1:0] rx_thr,
  input logic [31:0]    rdata,
  input logic [2:0]     addr,
  input logic           irq_o
);
  AST_TX_RDY_LOW_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_i |-> !tx_ready); // R2
  AST_RX_RDY_HIGH_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_i |-> rx_ready); // R3
  AST_GAP_CLEARS_ON_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_i |=> !gap); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en && !rx_en) |=> !irq_o); // R5
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tx_en && tx_ready) || (rx_en && rx_ready)) |=> irq_o); // R7
  AST_THR_CLAMPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(tx_thr) <= TX_DEPTH) && (32'(rx_thr) <= RX_DEPTH)); // R6
  AST_OCC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr == 3'd6) |-> (rdata <= RX_DEPTH)); // R1
endmodule

bind uart_fifo_irq_ctrl uart_fifo_irq_ctrl_chk #(
  .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .TLW(TLW), .RLW(RLW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_full_i(tx_full_i), .rx_full_i(rx_full_i),
  .rx_empty_i(rx_empty_i), .tx_ready(tx_ready_w), .rx_ready(rx_ready_w),
  .gap(gap_w), .tx_en(tx_en_w), .rx_en(rx_en_w), .tx_thr(tx_thr_w),
  .rx_thr(rx_thr_w), .rdata(reg_rdata_o), .addr(reg_addr_i), .irq_o(irq_o)
);

// File: tb/uart_fifo_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_fifo_irq_ctrl_tb;
  localparam int TXD = 16;
  localparam int RXD = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int tx_cnt = 0, rx_cnt = 0;
  logic gap_p = 1'b0, we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  uart_fifo_irq_ctrl #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_used_i(4'(tx_cnt % TXD)), .tx_full_i(tx_cnt == TXD), .tx_empty_i(tx_cnt == 0),
    .rx_used_i(5'(rx_cnt % RXD)), .rx_full_i(rx_cnt == RXD), .rx_empty_i(rx_cnt == 0),
    .rx_gap_tmo_i(gap_p), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // reference model state
  bit m_txen, m_rxen, m_gap, m_irq;
  int m_txthr, m_rxthr;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  function automatic bit f_tx_rdy();
    return (tx_cnt <= m_txthr) && (tx_cnt != TXD);
  endfunction
  function automatic bit f_rx_hit();
    return (rx_cnt >= m_rxthr) || (rx_cnt == RXD);
  endfunction
  function automatic logic [31:0] f_rd(input logic [2:0] a);
    logic [31:0] v = '0;
    case (a)
      3'd2: begin
        v[0] = f_tx_rdy(); v[1] = f_rx_hit() || m_gap;
        v[2] = tx_cnt == TXD; v[3] = rx_cnt == RXD;
        v[4] = tx_cnt == 0;   v[5] = rx_cnt == 0;
        v[13] = f_rx_hit();   v[14] = m_gap;
      end
      3'd3: v = {30'd0, m_rxen, m_txen};
      3'd4: v = 32'(m_txthr);
      3'd5: v = 32'(m_rxthr);
      3'd6: v = 32'(rx_cnt);
      3'd7: v = 32'(tx_cnt);
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_txen = 0; m_rxen = 0; m_gap = 0; m_irq = 0; m_txthr = 0; m_rxthr = 1;
    end else begin
      bit nirq, ngap;
      nirq = (m_txen && f_tx_rdy()) || (m_rxen && (f_rx_hit() || m_gap));
      ngap = (rx_cnt != 0) && (gap_p || (m_gap && !(we && addr == 3'd2 && wdata[14])));
      if (we) begin
        case (addr)
          3'd3: begin m_txen = wdata[0]; m_rxen = wdata[1]; end
          3'd4: m_txthr = (wdata > TXD) ? TXD : int'(wdata);
          3'd5: m_rxthr = (wdata > RXD) ? RXD : int'(wdata);
          default: ;
        endcase
      end
      m_irq = nirq; m_gap = ngap;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string addr_tag(input logic [2:0] a);
    case (a)
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      3'd6, 3'd7: return "R1";
      default: return "R8";
    endcase
  endfunction

  // per-cycle comparison
  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 irq", {31'd0, irq}, {31'd0, m_irq});
    chk(addr_tag(addr), rdata, f_rd(addr));
  end

  task automatic finish_sim();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected < 20000", cyc);
      finish_sim();
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d; tick(); we = 0; wdata = '0;
  endtask
  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] e);
    addr = a; #0.5; chk(tag, rdata, e);
  endtask

  initial begin
    tick(); tick();
    rst_n = 1'b1; tick();
    // R8 reset state
    chk("R8 irq", {31'd0, irq}, 32'd0);
    rd("R8 ctrl", 3'd3, 32'd0);
    rd("R8 txthr", 3'd4, 32'd0);
    rd("R8 rxthr", 3'd5, 32'd1);
    rd("R8 off0", 3'd0, 32'd0);
    rd("R8 off1", 3'd1, 32'd0);
    wr(3'd6, 32'hFF); wr(3'd1, 32'hFF);
    rd("R8 ro write", 3'd6, 32'd0);
    // R6 clamp and readback
    wr(3'd4, 32'd100); rd("R6 tx clamp", 3'd4, 32'd16);
    wr(3'd5, 32'd40);  rd("R6 rx clamp", 3'd5, 32'd32);
    wr(3'd4, 32'd2);   rd("R6 tx thr", 3'd4, 32'd2);
    wr(3'd5, 32'd5);   rd("R6 rx thr", 3'd5, 32'd5);
    // R1 occupancy with wrap
    tx_cnt = 16; rx_cnt = 32; tick();
    rd("R1 tx full occ", 3'd7, 32'd16);
    rd("R1 rx full occ", 3'd6, 32'd32);
    tx_cnt = 9; rx_cnt = 7; tick();
    rd("R1 tx occ", 3'd7, 32'd9);
    rd("R1 rx occ", 3'd6, 32'd7);
    // R2/R7 TX fill to full with irq enabled
    tx_cnt = 0; rx_cnt = 0; wr(3'd3, 32'd1); addr = 3'd2;
    for (int i = 0; i <= TXD; i++) begin tx_cnt = i; tick(); end
    tick();
    chk("R7 tx full irq", {31'd0, irq}, 32'd0);
    rd("R2 tx full status", 3'd2, 32'h0000_0024);
    tx_cnt = 1; tick(); tick();
    chk("R2 tx at thr irq", {31'd0, irq}, 32'd1);
    // R3/R7 RX fill to full
    tx_cnt = 10; wr(3'd3, 32'd2); addr = 3'd2;
    for (int i = 0; i <= RXD; i++) begin rx_cnt = i; tick(); end
    tick();
    chk("R7 rx full irq", {31'd0, irq}, 32'd1);
    rd("R3 rx full thr bit", 3'd2, 32'h0000_200A);
    rx_cnt = 4; tick(); tick();
    chk("R3 rx below thr", {31'd0, irq}, 32'd0);
    // R4 gap flag
    rx_cnt = 0; tick();
    gap_p = 1; tick(); gap_p = 0; tick();
    rd("R4 pulse on empty ignored", 3'd2, 32'h0000_0020);
    rx_cnt = 2; tick();
    gap_p = 1; tick(); gap_p = 0;
    rd("R4 gap set", 3'd2, 32'h0000_4002);
    tick();
    chk("R4 gap irq", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h0000_4000);
    rd("R4 w1c", 3'd2, 32'd0);
    gap_p = 1; wr(3'd2, 32'h0000_4000); gap_p = 0;
    rd("R4 set beats clear", 3'd2, 32'h0000_4002);
    rx_cnt = 0; tick();
    rd("R4 empty clears", 3'd2, 32'h0000_0020);
    // R5 masking
    rx_cnt = 32; wr(3'd3, 32'd0); tick(); tick();
    chk("R5 masked", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'd3); tick();
    chk("R5 enabled", {31'd0, irq}, 32'd1);
    tick(); tick();
    finish_sim();
  end
endmodule